// File: doc/BRIEF.md
# Indirect Register Address Resolver

This unit sits between the instruction decoder of a small processor core and its register file. For a direct access it builds the data-memory address from the register field of the instruction and a two-bit bank choice. When the instruction names register 00h, which holds no storage and stands for "the location the pointer selects", the unit instead issues an address made from a bank-select bit of the status register placed above the 8-bit pointer register.

A pointer that itself lands on the virtual register gets special treatment. A read returns 00h in place of the register file data. A write is blocked from the register file while the status-flag update stays enabled. All resolution is combinational: the register file sees the resolved address, write enable and read data in the same cycle as the instruction field.

Top module: `indirect_addr_unit`

## Requirements
- R1: When the register field is not 00h, `addr_o` equals {`dir_bank_i`, `reg_field_i`}, `indirect_o` is 0, and the pointer and the upper status bit have no effect on the address.
- R2: When the register field is 00h, `indirect_o` is 1 and `addr_o` equals {`irp_i`, `ptr_i`}, a 9-bit value.
- R3: In an indirect access `irp_i` is address bit 8, and `dir_bank_i` has no effect on `addr_o`.
- R4: An indirect read (`rd_i` = 1) whose pointer is self-referencing drives `rdata_o` to 00h whatever `rf_rdata_i` holds.
- R5: In every other case, including a self-referencing access with `rd_i` = 0, `rdata_o` equals `rf_rdata_i`.
- R6: An indirect write (`wr_i` = 1) whose pointer is self-referencing gives `wr_en_o` = 0, `wr_suppress_o` = 1 and `flag_en_o` = 1.
- R7: In every other case `wr_en_o` equals `wr_i`, `wr_suppress_o` is 0, and `flag_en_o` always equals `wr_i`.
- R8: With the default `SELF_ANY_BANK` = 1 the pointer is self-referencing when its low 7 bits are zero (00h or 80h); with 0 only a pointer of exactly 00h is.
- R9: All outputs follow their inputs in the same cycle, with no clock edge in between.
- R10: A loop that writes zero through the pointer to 20h..2Fh clears exactly those locations and leaves 1Fh and 30h unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_field_i | input | 7 | Register field of the current instruction |
| dir_bank_i | input | 2 | Bank choice for direct accesses |
| ptr_i | input | 8 | File-select pointer register value |
| irp_i | input | 1 | Indirect bank bit from the status register |
| rd_i | input | 1 | Data read strobe |
| wr_i | input | 1 | Data write strobe |
| rf_rdata_i | input | 8 | Read data from the register file |
| addr_o | output | 9 | Resolved register file address |
| indirect_o | output | 1 | Access goes through the pointer |
| rdata_o | output | 8 | Read data to the datapath |
| wr_en_o | output | 1 | Write enable to the register file |
| wr_suppress_o | output | 1 | Self-referencing write was blocked |
| flag_en_o | output | 1 | Status-flag update enable |

## Verification
The bench builds the unit with its defaults: a 7-bit field, a 2-bit direct bank, an 8-bit pointer, 8-bit data and `SELF_ANY_BANK` = 1. With these, pointer values 00h and 80h both reach the self-reference path, so the bank-1 image of the virtual register is exercised next to the plain zero pointer, and the full 9-bit address range including 1FFh is reachable from both the direct and the indirect side. A bench-side register file lets a pointer loop clear a window and read it back through direct accesses.

// File: rtl/indirect_addr_pkg.sv
package indirect_addr_pkg;
  localparam int unsigned FIELD_W_DEF = 7;
  localparam int unsigned BANK_W_DEF  = 2;
  localparam int unsigned PTR_W_DEF   = 8;
  localparam int unsigned DATA_W_DEF  = 8;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_SELF     = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/indirect_addr_decode.sv
module indirect_addr_decode
  import indirect_addr_pkg::*;
#(
  parameter int unsigned FIELD_W       = FIELD_W_DEF,
  parameter int unsigned PTR_W         = PTR_W_DEF,
  parameter bit          SELF_ANY_BANK = 1'b1
) (
  input  logic [FIELD_W-1:0] reg_field_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output acc_kind_e          kind_o
);
  logic is_ind;
  logic ptr_self;

  assign is_ind = (reg_field_i == '0);

  generate
    if (SELF_ANY_BANK) begin : g_any_bank
      // pointer hits the virtual register in whichever bank it lands
      logic unused_ptr_hi;
      assign unused_ptr_hi = &{1'b0, ptr_i[PTR_W-1:FIELD_W]};
      assign ptr_self = (ptr_i[FIELD_W-1:0] == '0);
    end else begin : g_exact
      assign ptr_self = (ptr_i == '0);
    end
  endgenerate

  always_comb begin
    if (!is_ind)       kind_o = ACC_DIRECT;
    else if (ptr_self) kind_o = ACC_SELF;
    else               kind_o = ACC_INDIRECT;
  end
endmodule

// File: rtl/indirect_addr_mux.sv
module indirect_addr_mux
  import indirect_addr_pkg::*;
#(
  parameter int unsigned FIELD_W = FIELD_W_DEF,
  parameter int unsigned BANK_W  = BANK_W_DEF,
  parameter int unsigned PTR_W   = PTR_W_DEF,
  localparam int unsigned ADDR_W = FIELD_W + BANK_W
) (
  input  acc_kind_e          kind_i,
  input  logic [FIELD_W-1:0] reg_field_i,
  input  logic [BANK_W-1:0]  dir_bank_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic               irp_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] ind_addr;

  assign dir_addr = {dir_bank_i, reg_field_i};
  assign ind_addr = ADDR_W'({irp_i, ptr_i});

  always_comb begin
    unique case (kind_i)
      ACC_DIRECT: addr_o = dir_addr;
      default:    addr_o = ind_addr;
    endcase
  end
endmodule

// File: rtl/indirect_addr_guard.sv
module indirect_addr_guard
  import indirect_addr_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  acc_kind_e          kind_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               wr_en_o,
  output logic               wr_suppress_o,
  output logic               flag_en_o
);
  logic self_ref;
  assign self_ref = (kind_i == ACC_SELF);

  assign rdata_o       = (self_ref && rd_i) ? '0 : rf_rdata_i;
  assign wr_suppress_o = self_ref && wr_i;
  assign wr_en_o       = wr_i && !self_ref;
  // flags still update on a blocked write
  assign flag_en_o     = wr_i;
endmodule

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit
  import indirect_addr_pkg::*;
#(
  parameter int unsigned FIELD_W       = FIELD_W_DEF,
  parameter int unsigned BANK_W        = BANK_W_DEF,
  parameter int unsigned PTR_W         = PTR_W_DEF,
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter bit          SELF_ANY_BANK = 1'b1,
  localparam int unsigned ADDR_W       = FIELD_W + BANK_W
) (
  input  logic [FIELD_W-1:0] reg_field_i,
  input  logic [BANK_W-1:0]  dir_bank_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic               irp_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               indirect_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               wr_en_o,
  output logic               wr_suppress_o,
  output logic               flag_en_o
);
  acc_kind_e kind;

  indirect_addr_decode #(
    .FIELD_W      (FIELD_W),
    .PTR_W        (PTR_W),
    .SELF_ANY_BANK(SELF_ANY_BANK)
  ) u_decode (
    .reg_field_i(reg_field_i),
    .ptr_i      (ptr_i),
    .kind_o     (kind)
  );

  indirect_addr_mux #(
    .FIELD_W(FIELD_W),
    .BANK_W (BANK_W),
    .PTR_W  (PTR_W)
  ) u_mux (
    .kind_i     (kind),
    .reg_field_i(reg_field_i),
    .dir_bank_i (dir_bank_i),
    .ptr_i      (ptr_i),
    .irp_i      (irp_i),
    .addr_o     (addr_o)
  );

  indirect_addr_guard #(
    .DATA_W(DATA_W)
  ) u_guard (
    .kind_i       (kind),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .rf_rdata_i   (rf_rdata_i),
    .rdata_o      (rdata_o),
    .wr_en_o      (wr_en_o),
    .wr_suppress_o(wr_suppress_o),
    .flag_en_o    (flag_en_o)
  );

  assign indirect_o = (kind != ACC_DIRECT);
endmodule

// File: rtl/indirect_addr_unit_chk.sv
module indirect_addr_unit_chk #(
  parameter int unsigned FIELD_W       = 7,
  parameter int unsigned BANK_W        = 2,
  parameter int unsigned PTR_W         = 8,
  parameter int unsigned DATA_W        = 8,
  parameter bit          SELF_ANY_BANK = 1'b1,
  localparam int unsigned ADDR_W       = FIELD_W + BANK_W
) (
  input logic [FIELD_W-1:0] reg_field_i,
  input logic [BANK_W-1:0]  dir_bank_i,
  input logic [PTR_W-1:0]   ptr_i,
  input logic               irp_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  rf_rdata_i,
  input logic [ADDR_W-1:0]  addr_o,
  input logic               indirect_o,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               wr_en_o,
  input logic               wr_suppress_o,
  input logic               flag_en_o
);
  logic field_zero;
  logic self_ptr;
  assign field_zero = (reg_field_i == '0);
  assign self_ptr   = SELF_ANY_BANK ? (ptr_i[FIELD_W-1:0] == '0) : (ptr_i == '0);

  always_comb begin
    if (!field_zero) begin
      assert_direct_addr_R1: assert (!indirect_o && addr_o == {dir_bank_i, reg_field_i})
        else $error("direct address mismatch");
    end
    if (field_zero) begin
      assert_indirect_addr_R2: assert (indirect_o && addr_o == ADDR_W'({irp_i, ptr_i}))
        else $error("indirect address mismatch");
    end
    if (field_zero && self_ptr && rd_i) begin
      assert_self_read_zero_R4: assert (rdata_o == '0)
        else $error("self read not zero");
    end
    if (!(field_zero && self_ptr && rd_i)) begin
      assert_read_pass_R5: assert (rdata_o == rf_rdata_i)
        else $error("read data not passed");
    end
    if (wr_suppress_o) begin
      assert_suppress_keeps_flags_R6: assert (!wr_en_o && flag_en_o)
        else $error("suppressed write leaked");
    end
    if (!(field_zero && self_ptr)) begin
      assert_write_pass_R7: assert (wr_en_o == wr_i && !wr_suppress_o && flag_en_o == wr_i)
        else $error("write path mismatch");
    end
  end
endmodule

bind indirect_addr_unit indirect_addr_unit_chk #(
  .FIELD_W      (FIELD_W),
  .BANK_W       (BANK_W),
  .PTR_W        (PTR_W),
  .DATA_W       (DATA_W),
  .SELF_ANY_BANK(SELF_ANY_BANK)
) u_chk (
  .reg_field_i  (reg_field_i),
  .dir_bank_i   (dir_bank_i),
  .ptr_i        (ptr_i),
  .irp_i        (irp_i),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .rf_rdata_i   (rf_rdata_i),
  .addr_o       (addr_o),
  .indirect_o   (indirect_o),
  .rdata_o      (rdata_o),
  .wr_en_o      (wr_en_o),
  .wr_suppress_o(wr_suppress_o),
  .flag_en_o    (flag_en_o)
);

// File: tb/tb_indirect_addr_unit.sv
module tb_indirect_addr_unit;
  typedef struct packed {
    logic [6:0] field;
    logic [1:0] bank;
    logic [7:0] ptr;
    logic       irp;
    logic       rd;
    logic       wr;
    logic [7:0] rf;
    logic [8:0] e_addr;
    logic [7:0] e_rdata;
    logic       e_wren;
    logic       e_sup;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{7'h25, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h3C, 9'h025, 8'h3C, 1'b0, 1'b0}, // R1 R5
    '{7'h7F, 2'd3, 8'h44, 1'b1, 1'b0, 1'b1, 8'h00, 9'h1FF, 8'h00, 1'b1, 1'b0}, // R1 R7
    '{7'h00, 2'd2, 8'h25, 1'b1, 1'b1, 1'b0, 8'h77, 9'h125, 8'h77, 1'b0, 1'b0}, // R2 R3
    '{7'h00, 2'd1, 8'h25, 1'b0, 1'b1, 1'b0, 8'h77, 9'h025, 8'h77, 1'b0, 1'b0}, // R3
    '{7'h00, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'hA5, 9'h000, 8'h00, 1'b0, 1'b0}, // R4
    '{7'h00, 2'd3, 8'h80, 1'b1, 1'b1, 1'b0, 8'h5A, 9'h180, 8'h00, 1'b0, 1'b0}, // R4 R8
    '{7'h00, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 9'h000, 8'h11, 1'b0, 1'b1}, // R6
    '{7'h00, 2'd0, 8'h80, 1'b0, 1'b0, 1'b1, 8'h22, 9'h080, 8'h22, 1'b0, 1'b1}, // R8
    '{7'h00, 2'd0, 8'h81, 1'b0, 1'b0, 1'b1, 8'h22, 9'h081, 8'h22, 1'b1, 1'b0}, // R7
    '{7'h00, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h99, 9'h000, 8'h99, 1'b0, 1'b0}, // R5
    '{7'h01, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h66, 9'h001, 8'h66, 1'b0, 1'b0}, // R1
    '{7'h00, 2'd0, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h33, 9'h1FF, 8'h33, 1'b1, 1'b0}  // R2 R7
  };

  logic       clk;
  logic [6:0] reg_field;
  logic [1:0] dir_bank;
  logic [7:0] ptr;
  logic       irp, rd, wr;
  logic [7:0] vec_rf;
  logic       use_mem;
  logic [7:0] rf_rdata;
  logic [8:0] addr;
  logic       indirect, wr_en, wr_sup, flag_en;
  logic [7:0] rdata;
  logic [7:0] mem [512];

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign rf_rdata = use_mem ? mem[addr] : vec_rf;

  always_ff @(posedge clk) if (wr_en) mem[addr] <= 8'h00;

  indirect_addr_unit dut (
    .reg_field_i(reg_field), .dir_bank_i(dir_bank), .ptr_i(ptr), .irp_i(irp),
    .rd_i(rd), .wr_i(wr), .rf_rdata_i(rf_rdata),
    .addr_o(addr), .indirect_o(indirect), .rdata_o(rdata),
    .wr_en_o(wr_en), .wr_suppress_o(wr_sup), .flag_en_o(flag_en)
  );

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] f, input logic [1:0] b, input logic [7:0] p,
                       input logic i, input logic r, input logic w);
    reg_field = f; dir_bank = b; ptr = p; irp = i; rd = r; wr = w;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    use_mem = 1'b0; vec_rf = 8'h00;
    drive(7'h10, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    for (int a = 0; a < 512; a++) mem[a] = 8'(a) ^ 8'hC3;
    #1;
    // idle strobes: nothing written, nothing flagged
    chk("R7", "idle wr_en", 9'(wr_en), 9'd0);
    chk("R7", "idle flag_en", 9'(flag_en), 9'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k].field, VECS[k].bank, VECS[k].ptr, VECS[k].irp, VECS[k].rd, VECS[k].wr);
      vec_rf = VECS[k].rf;
      #1;
      chk("R1/R2/R3", "addr", addr, VECS[k].e_addr);
      chk("R2", "indirect", 9'(indirect), 9'(VECS[k].field == 7'h00));
      chk("R4/R5", "rdata", 9'(rdata), 9'(VECS[k].e_rdata));
      chk("R6/R7", "wr_en", 9'(wr_en), 9'(VECS[k].e_wren));
      chk("R6/R7", "suppress", 9'(wr_sup), 9'(VECS[k].e_sup));
      chk("R6/R7", "flag_en", 9'(flag_en), 9'(VECS[k].wr));
    end

    // R9: pointer change settles with no clock edge
    @(negedge clk);
    drive(7'h00, 2'd0, 8'h40, 1'b0, 1'b1, 1'b0);
    #1;
    ptr = 8'h41;
    #0.5;
    chk("R9", "addr same cycle", addr, 9'h041);

    // R3: bank choice ignored for indirect
    dir_bank = 2'd3;
    #0.5;
    chk("R3", "bank ignored", addr, 9'h041);

    // R10: clear 20h..2Fh through the pointer
    use_mem = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      drive(7'h00, 2'd0, 8'h20 + 8'(i), 1'b0, 1'b0, 1'b1);
      @(posedge clk);
    end
    // self-referencing write must not reach storage
    @(negedge clk);
    drive(7'h00, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    @(posedge clk);
    @(negedge clk);
    drive(7'h00, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    for (int a = 8'h1F; a <= 8'h30; a++) begin
      @(negedge clk);
      drive(7'(a), 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
      #1;
      if (a >= 8'h20 && a <= 8'h2F)
        chk("R10", "cleared", 9'(rdata), 9'h000);
      else
        chk("R10", "outside kept", 9'(rdata), 9'(8'(a) ^ 8'hC3));
    end
    @(negedge clk);
    drive(7'h00, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R6", "mem[0] untouched", 9'(rdata), 9'(8'h00 ^ 8'hC3));
    // R4: same location read through self pointer returns zero
    rd = 1'b1;
    #1;
    chk("R4", "self read zero", 9'(rdata), 9'h000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule